// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock for an I2C master from a fast system clock. A single 8-bit control register sets the divisor (a 5-bit rate value), a standard/fast speed select, whether a ninth acknowledge clock follows the data clocks, and the level driven on the data line during that ninth clock. A one-cycle start strobe, taken while the interface is enabled, makes the block emit one byte's worth of clocks. It then reports completion with a one-cycle done pulse.

Both lines are open-drain. Each output means "pull the line low", and a 0 leaves the line released (high). The block drives the data line only during the acknowledge clock. The data shift register, start/stop conditions, arbitration and clock stretching belong to neighbouring logic.

Control register layout: bit 7 enables the acknowledge clock. Bit 6 sets the acknowledge level (0 = acknowledge, 1 = no acknowledge). Bit 5 selects the speed (0 = standard, 1 = fast). Bits 4..0 hold the rate value.

Top module: `i2c_sclgen`

## Requirements
- R1: After reset the control register is 00h. Both line outputs are 0 (released), `byte_done` is 0 and `rate_err` is 1, because the rate value is 0.
- R2: In standard mode (bit 5 = 0) one clock period lasts 8 × value cycles. `scl_low` is 1 for the first floor(period/2) cycles of each period and 0 for the remaining cycles. The first low cycle is the cycle right after the accepted start strobe.
- R3: In fast mode (bit 5 = 1) with a rate value other than 5, one period lasts 4 × value cycles, split as in R2.
- R4: In fast mode with a rate value of exactly 5, one period lasts 10 cycles.
- R5: Rate values 0, 1 and 2 time the clock as value 3. While the stored value is below 3, `rate_err` is 1; otherwise it is 0.
- R6: A register write while `enable` is 1 leaves bits 5..0 unchanged but still updates bits 7 and 6. A write while `enable` is 0 updates all bits.
- R7: With bit 7 = 1 a byte has nine clocks; with bit 7 = 0 it has eight.
- R8: During both halves of the ninth clock, `sda_low` equals the inverse of bit 6 as sampled at the start strobe. At all other times `sda_low` is 0.
- R9: `byte_done` is 1 for exactly the one cycle after the last clock's high half. A start strobe in that cycle begins a new byte, and `scl_low` is 1 in the next cycle.
- R10: A start strobe while a byte is in progress, or while `enable` is 0, is ignored.
- R11: When `enable` is 0 at a clock edge, a byte in progress is abandoned. In the next cycle both line outputs and `byte_done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| enable | input | 1 | Interface enable |
| byte_start | input | 1 | One-cycle request to clock out one byte |
| scl_low | output | 1 | Pull the clock line low (0 = released) |
| sda_low | output | 1 | Pull the data line low during the acknowledge clock |
| byte_done | output | 1 | One-cycle pulse when the byte's clocks have ended |
| rate_err | output | 1 | Stored rate value is below the legal minimum |

## Verification
An accepted start strobe shows `scl_low` high in the very next cycle. `byte_done` then appears exactly clocks × period + 1 cycles after the strobe edge. A register write changes `rate_err` in the cycle after its edge. Dropping `enable` clears every output one cycle later.

The bench's reference model sees the same inputs at each rising edge and predicts the outputs that follow that edge. The outputs are compared at the falling edge, half a cycle after they settle. Directed checks count cycles from the strobe to the done pulse and count low phases. This catches both a wrong period and a wrong number of clocks.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

    localparam int RATE_W   = 5;
    localparam int MIN_RATE = 3;
    localparam int FAST_SPECIAL_RATE   = 5;
    localparam int FAST_SPECIAL_PERIOD = 10;

    typedef enum logic [1:0] {
        SG_IDLE,
        SG_LOW,
        SG_HIGH,
        SG_DONE
    } sg_state_e;

    typedef struct packed {
        logic              ack_clk_en;  // bit 7
        logic              ack_nack;    // bit 6
        logic              fast_mode;   // bit 5
        logic [RATE_W-1:0] rate;        // bits 4..0
    } sg_ctrl_t;

endpackage

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
    import i2c_sclgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       enable,
    output sg_ctrl_t   ctrl,
    output logic       rate_err
);

    sg_ctrl_t ctrl_d, ctrl_q;
    sg_ctrl_t wr_view;

    always_comb begin
        wr_view = sg_ctrl_t'(wr_data);
        ctrl_d  = ctrl_q;
        if (wr_en) begin
            // acknowledge controls may change at any time
            ctrl_d.ack_clk_en = wr_view.ack_clk_en;
            ctrl_d.ack_nack   = wr_view.ack_nack;
            // timing controls only while the interface is off
            if (!enable) begin
                ctrl_d.fast_mode = wr_view.fast_mode;
                ctrl_d.rate      = wr_view.rate;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl     = ctrl_q;
    assign rate_err = (ctrl_q.rate < RATE_W'(MIN_RATE));

endmodule

// File: rtl/sclgen_timing.sv
module sclgen_timing
    import i2c_sclgen_pkg::*;
#(
    parameter int CNT_W = RATE_W + 4
) (
    input  sg_ctrl_t         ctrl,
    output logic [CNT_W-1:0] lo_len,
    output logic [CNT_W-1:0] hi_len
);

    logic [RATE_W-1:0] eff_rate;
    logic [CNT_W-1:0]  period;

    always_comb begin
        eff_rate = (ctrl.rate < RATE_W'(MIN_RATE)) ? RATE_W'(MIN_RATE) : ctrl.rate;
        if (!ctrl.fast_mode) begin
            period = CNT_W'(eff_rate) << 3;
        end else if (eff_rate == RATE_W'(FAST_SPECIAL_RATE)) begin
            period = CNT_W'(FAST_SPECIAL_PERIOD);
        end else begin
            period = CNT_W'(eff_rate) << 2;
        end
        lo_len = period >> 1;
        hi_len = period - lo_len;
    end

endmodule

// File: rtl/sclgen_seq.sv
module sclgen_seq
    import i2c_sclgen_pkg::*;
#(
    parameter int CNT_W     = RATE_W + 4,
    parameter int DATA_CLKS = 8,
    localparam int BIT_W    = $clog2(DATA_CLKS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] lo_len,
    input  logic [CNT_W-1:0] hi_len,
    input  logic             ack_clk_en,
    input  logic             ack_nack,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done
);

    typedef struct packed {
        sg_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
        logic [BIT_W-1:0] last_bit;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic             nack;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.st  = SG_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                SG_IDLE, SG_DONE: begin
                    if (start) begin
                        s_d.st       = SG_LOW;
                        s_d.cnt      = '0;
                        s_d.bitn     = '0;
                        s_d.lo       = lo_len;
                        s_d.hi       = hi_len;
                        s_d.nack     = ack_nack;
                        s_d.last_bit = ack_clk_en ? BIT_W'(DATA_CLKS)
                                                  : BIT_W'(DATA_CLKS - 1);
                    end else begin
                        s_d.st = SG_IDLE;
                    end
                end
                SG_LOW: begin
                    if (s_q.cnt == s_q.lo - CNT_W'(1)) begin
                        s_d.st  = SG_HIGH;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                SG_HIGH: begin
                    if (s_q.cnt == s_q.hi - CNT_W'(1)) begin
                        s_d.cnt = '0;
                        if (s_q.bitn == s_q.last_bit) begin
                            s_d.st = SG_DONE;
                        end else begin
                            s_d.st   = SG_LOW;
                            s_d.bitn = s_q.bitn + BIT_W'(1);
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                default: s_d.st = SG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= SG_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    logic in_clock;
    assign in_clock = (s_q.st == SG_LOW) || (s_q.st == SG_HIGH);
    assign scl_low  = (s_q.st == SG_LOW);
    assign sda_low  = in_clock && (s_q.bitn == BIT_W'(DATA_CLKS)) && !s_q.nack;
    assign done     = (s_q.st == SG_DONE);

endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
    import i2c_sclgen_pkg::*;
#(
    parameter int DATA_CLKS = 8,
    localparam int CNT_W    = RATE_W + 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       enable,
    input  logic       byte_start,
    output logic       scl_low,
    output logic       sda_low,
    output logic       byte_done,
    output logic       rate_err
);

    sg_ctrl_t         ctrl;
    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] hi_len;

    sclgen_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .enable   (enable),
        .ctrl     (ctrl),
        .rate_err (rate_err)
    );

    sclgen_timing #(.CNT_W(CNT_W)) u_timing (
        .ctrl   (ctrl),
        .lo_len (lo_len),
        .hi_len (hi_len)
    );

    sclgen_seq #(.CNT_W(CNT_W), .DATA_CLKS(DATA_CLKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (byte_start),
        .lo_len     (lo_len),
        .hi_len     (hi_len),
        .ack_clk_en (ctrl.ack_clk_en),
        .ack_nack   (ctrl.ack_nack),
        .scl_low    (scl_low),
        .sda_low    (sda_low),
        .done       (byte_done)
    );

endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_low,
    input logic sda_low,
    input logic byte_done,
    input logic rate_err
);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R11
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_low && !sda_low && !byte_done));

    // R8
    ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> (scl_low && !$past(scl_low)));

    // R10
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> $past(enable));

    // R6
    rate_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(rate_err));

    // R9
    done_no_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!scl_low && !sda_low));

endmodule

bind i2c_sclgen sclgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .byte_done (byte_done),
    .rate_err  (rate_err)
);

// File: tb/sim_i2c_sclgen.sv
module sim_i2c_sclgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       enable = 1'b0;
    logic       byte_start = 1'b0;
    logic       scl_low, sda_low, byte_done, rate_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    i2c_sclgen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .enable     (enable),
        .byte_start (byte_start),
        .scl_low    (scl_low),
        .sda_low    (sda_low),
        .byte_done  (byte_done),
        .rate_err   (rate_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_rate = 0, m_fast = 0, m_ackclk = 0, m_nack = 0;
    int q[$];
    int exp_o = 0;
    bit model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rate = 0; m_fast = 0; m_ackclk = 0; m_nack = 0;
            q.delete();
            exp_o = 0;
        end else begin
            if (!enable) begin
                q.delete();
            end else if (q.size() == 0 && byte_start) begin
                int eff, per, lo, hi, n;
                eff = (m_rate < 3) ? 3 : m_rate;
                if (m_fast == 0)     per = 8 * eff;
                else if (eff == 5)   per = 10;
                else                 per = 4 * eff;
                lo = per / 2;
                hi = per - lo;
                n  = m_ackclk ? 9 : 8;
                for (int k = 0; k < n; k++) begin
                    int sd;
                    sd = (k == 8 && m_nack == 0) ? 2 : 0;
                    for (int c = 0; c < lo; c++) q.push_back(4 + sd);
                    for (int c = 0; c < hi; c++) q.push_back(sd);
                end
                q.push_back(1);
            end
            exp_o = (q.size() > 0) ? q.pop_front() : 0;
            if (reg_wr) begin
                m_ackclk = reg_wdata[7];
                m_nack   = reg_wdata[6];
                if (!enable) begin
                    m_fast = reg_wdata[5];
                    m_rate = reg_wdata[4:0];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(scl_low == exp_o[2], "R2 model scl_low", scl_low, exp_o[2]);
            check(sda_low == exp_o[1], "R8 model sda_low", sda_low, exp_o[1]);
            check(byte_done == exp_o[0], "R9 model byte_done", byte_done, exp_o[0]);
            check(rate_err == (m_rate < 3), "R5 model rate_err", rate_err, m_rate < 3);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_byte(input int nclk, input int per, input string tag,
                            input bit poke_busy, input bit restart);
        int cyc = 0, rises = 0, sda_seen = 0;
        bit prev = 0;
        @(negedge clk);
        byte_start = 1'b1;
        while (1) begin
            @(negedge clk);
            byte_start = 1'b0;
            cyc++;
            if (scl_low && !prev) rises++;
            if (sda_low) sda_seen++;
            prev = scl_low;
            if (poke_busy && cyc == 5) byte_start = 1'b1;
            if (byte_done || cyc > 3000) break;
        end
        check(cyc == nclk * per + 1, {tag, " cycles to done"}, cyc, nclk * per + 1);
        check(rises == nclk, {tag, " clock count"}, rises, nclk);
        if (restart) begin
            byte_start = 1'b1;
            @(negedge clk);
            byte_start = 1'b0;
            check(scl_low == 1'b1, "R9 restart in done cycle", scl_low, 1);
            cyc = 0;
            while (!byte_done && cyc < 3000) begin
                @(negedge clk);
                cyc++;
            end
        end
    endtask

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(scl_low == 0, "R1 reset scl_low", scl_low, 0);
        check(sda_low == 0, "R1 reset sda_low", sda_low, 0);
        check(byte_done == 0, "R1 reset byte_done", byte_done, 0);
        check(rate_err == 1, "R1 reset rate_err", rate_err, 1);
        rst_n = 1'b1;
        model_on = 1;

        // R5 legal value clears the error flag; R2 standard mode, value 4
        write_reg(8'h04);
        check(rate_err == 0, "R5 legal rate_err", rate_err, 0);
        enable = 1'b1;
        run_byte(8, 32, "R2 std v4", 0, 0);

        // R6 rate/mode write ignored while enabled, ack bits taken; R7 nine clocks
        write_reg(8'h8A);
        run_byte(9, 32, "R6 locked rate", 0, 0);
        // R8 ack level 0: sda_low over whole ninth clock (checked by model too)

        // R10 start while busy ignored
        run_byte(9, 32, "R10 busy start", 1, 0);

        // R4 fast mode value 5, eight clocks
        enable = 1'b0;
        write_reg(8'h25);
        enable = 1'b1;
        run_byte(8, 10, "R4 fast v5", 0, 0);

        // R3 fast mode value 7; R9 restart in done cycle
        enable = 1'b0;
        write_reg(8'h27);
        enable = 1'b1;
        run_byte(8, 28, "R3 fast v7", 0, 1);

        // R5 value 1 acts as 3; R7 ack clock; R8 no-acknowledge level
        enable = 1'b0;
        write_reg(8'hC1);
        check(rate_err == 1, "R5 illegal rate_err", rate_err, 1);
        enable = 1'b1;
        run_byte(9, 24, "R5 std v1 as 3", 0, 0);

        // R10 start while disabled ignored
        enable = 1'b0;
        @(negedge clk);
        byte_start = 1'b1;
        @(negedge clk);
        byte_start = 1'b0;
        begin
            int lows = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (scl_low) lows++;
            end
            check(lows == 0, "R10 disabled start", lows, 0);
        end

        // R11 abort mid-byte
        enable = 1'b1;
        @(negedge clk);
        byte_start = 1'b1;
        @(negedge clk);
        byte_start = 1'b0;
        repeat (6) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_low == 0 && byte_done == 0, "R11 abort release", scl_low, 0);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule